// File: doc/BRIEF.md
# Fan tachometer capture channel

This block measures one fan's speed as a period. A 16-bit counter starts at its all-ones value and steps down by one on every prescaled tick. An edge on the chosen tachometer pin ends the measurement. The remaining count holds the period: 0xFFFF minus the number of ticks since the measurement began. A fan gives two tachometer pulses per revolution, so a full revolution spans two such periods.

A measurement can end in one of three ways, and each has its own single-cycle strobe:
- **Capture.** An edge arrives and the count is copied into the capture register.
- **Compare stop.** A programmed condition on the count is met, and the count freezes where it stands.
- **Underflow.** The counter would step below zero before any edge arrives.

The channel holds its last value until the next tick. That tick reloads the counter to all ones and a new measurement starts at once. The register file around the channel owns the configuration inputs, and the interrupt logic consumes the strobes.

Top module: `fan_tach_channel`

## Requirements
- R1: Out of reset, count_o is 0xFFFF, capture_o is 0 and all three strobes are low. While measuring, each cycle with tick_i high lowers count_o by exactly one, unless that cycle ends the measurement.
- R2: The channel is active only while mode_meas_i, chan_en_i and clk_gate_i are all 1. While any of them is 0, count_o is held at 0xFFFF, ticks and pin edges have no effect, and no strobe fires.
- R3: tach_sel_i = 0 routes tach_a_i to the channel and tach_sel_i = 1 routes tach_b_i. Edges on the other pin cause no strobe.
- R4: A counted edge on the routed pin copies the current count into capture_o and raises cap_evt_o for one cycle. The strobe follows the pin transition within eight cycles.
- R5: A tick that arrives while the count is 0, with no edge and no compare stop in that cycle, raises ufl_evt_o. The count is left at 0 and capture_o keeps its previous value.
- R6: cmp_cfg_i bit 3 stops the measurement at once, at count 0xFFFF. Bit 2 stops it when the count equals cmp_val_i. Bit 1 stops it when the count equals cmp_val_i minus one, and only if cmp_val_i is nonzero. A stop raises hit_evt_o, leaves capture_o unchanged and freezes the count at the stop value.
- R7: Only the highest set bit among 3, 2 and 1 of cmp_cfg_i applies. For example, bits 3 and 2 together stop at 0xFFFF, whatever cmp_val_i is.
- R8: edge_rise_i = 1 counts low-to-high transitions and edge_rise_i = 0 counts high-to-low transitions. A transition in the other direction is ignored.
- R9: cmp_cfg_i bit 0 is a source-select field for the surrounding logic. It does not change any outcome of this channel.
- R10: At most one strobe is high in any cycle. A single outcome gives a strobe lasting exactly one cycle.
- R11: After any outcome, count_o holds its value until the next tick. That tick reloads it to 0xFFFF and starts a new measurement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Prescaled count enable, one cycle per tick |
| tach_a_i | input | 1 | Tachometer pin A (asynchronous) |
| tach_b_i | input | 1 | Tachometer pin B (asynchronous) |
| tach_sel_i | input | 1 | 0 selects pin A, 1 selects pin B |
| mode_meas_i | input | 1 | Measurement mode select |
| chan_en_i | input | 1 | Channel enable |
| clk_gate_i | input | 1 | Channel clock select |
| edge_rise_i | input | 1 | 1 counts rising edges, 0 counts falling edges |
| cmp_cfg_i | input | 4 | Compare stop configuration (bits 3..1 rules, bit 0 source select) |
| cmp_val_i | input | 16 | Compare target |
| count_o | output | 16 | Live down-counter |
| capture_o | output | 16 | Last captured count |
| cap_evt_o | output | 1 | Capture strobe |
| hit_evt_o | output | 1 | Compare-stop strobe |
| ufl_evt_o | output | 1 | Underflow strobe |

## Verification
The properties assume that tick_i, the control inputs and the compare inputs are synchronous to clk_i. They also assume that the compare configuration is not changed in the middle of a measurement. Only the two tachometer pins may change without regard to the clock. The bench keeps to these assumptions. It changes selection, polarity and compare settings only while chan_en_i is low, and it drives every input at the falling clock edge. It changes pin levels only when ticks are paused, so each captured count is fixed before the edge reaches the channel.

// File: rtl/fan_tach_pkg.sv
package fan_tach_pkg;
  localparam int unsigned CFG_W     = 4;
  localparam int unsigned CFG_FORCE = 3;  // stop at all-ones
  localparam int unsigned CFG_EQ    = 2;  // stop at target
  localparam int unsigned CFG_BELOW = 1;  // stop at target-1
  localparam int unsigned CFG_SRC   = 0;  // consumed outside the channel

  typedef enum logic [1:0] {
    OUT_NONE = 2'd0,
    OUT_CAP  = 2'd1,
    OUT_HIT  = 2'd2,
    OUT_UFL  = 2'd3
  } outcome_e;

  typedef enum logic {
    ST_RUN  = 1'b0,
    ST_DONE = 1'b1
  } meas_st_e;
endpackage

// File: rtl/fan_tach_sync.sv
module fan_tach_sync #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  generate
    if (STAGES <= 1) begin : g_single
      logic [WIDTH-1:0] flop_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) flop_q <= '0;
        else         flop_q <= d_i;
      end
      assign q_o = flop_q;
    end else begin : g_chain
      logic [STAGES-1:0][WIDTH-1:0] chain_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= '0;
        else         chain_q <= {chain_q[STAGES-2:0], d_i};
      end
      assign q_o = chain_q[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/fan_tach_edge.sv
module fan_tach_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic level_i,
  input  logic rise_i,
  output logic edge_o
);
  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= level_i;
  end

  assign edge_o = rise_i ? (level_i & ~prev_q) : (~level_i & prev_q);
endmodule

// File: rtl/fan_tach_cmp.sv
module fan_tach_cmp
  import fan_tach_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] cmp_i,
  input  logic [CFG_W-1:0] cfg_i,
  output logic             stop_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] ONE     = {{(CNT_W-1){1'b0}}, 1'b1};

  logic at_max, at_eq, at_below;
  logic unused_src;

  assign unused_src = cfg_i[CFG_SRC];
  assign at_max     = (cnt_i == CNT_MAX);
  assign at_eq      = (cnt_i == cmp_i);
  assign at_below   = (|cmp_i) && (cnt_i == (cmp_i - ONE));

  // highest set rule wins; lower rules are not consulted
  always_comb begin
    if (cfg_i[CFG_FORCE])      stop_o = at_max;
    else if (cfg_i[CFG_EQ])    stop_o = at_eq;
    else if (cfg_i[CFG_BELOW]) stop_o = at_below;
    else                       stop_o = 1'b0;
  end
endmodule

// File: rtl/fan_tach_channel.sv
module fan_tach_channel
  import fan_tach_pkg::*;
#(
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             tach_a_i,
  input  logic             tach_b_i,
  input  logic             tach_sel_i,
  input  logic             mode_meas_i,
  input  logic             chan_en_i,
  input  logic             clk_gate_i,
  input  logic             edge_rise_i,
  input  logic [3:0]       cmp_cfg_i,
  input  logic [CNT_W-1:0] cmp_val_i,
  output logic [CNT_W-1:0] count_o,
  output logic [CNT_W-1:0] capture_o,
  output logic             cap_evt_o,
  output logic             hit_evt_o,
  output logic             ufl_evt_o
);
  localparam int unsigned      NUM_PINS = 2;
  localparam logic [CNT_W-1:0] CNT_MAX  = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] ONE      = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [NUM_PINS-1:0] pins_sync;
  logic                sel_level, edge_seen, stop_seen;
  logic                active, running;
  meas_st_e            st_q;
  logic [CNT_W-1:0]    cnt_q, cap_q;
  outcome_e            outc;
  logic                cap_evt_q, hit_evt_q, ufl_evt_q;

  fan_tach_sync #(
    .WIDTH (NUM_PINS),
    .STAGES(SYNC_STAGES)
  ) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({tach_b_i, tach_a_i}),
    .q_o   (pins_sync)
  );

  assign sel_level = pins_sync[tach_sel_i];

  fan_tach_edge u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .level_i(sel_level),
    .rise_i (edge_rise_i),
    .edge_o (edge_seen)
  );

  fan_tach_cmp #(
    .CNT_W(CNT_W)
  ) u_cmp (
    .cnt_i (cnt_q),
    .cmp_i (cmp_val_i),
    .cfg_i (cmp_cfg_i),
    .stop_o(stop_seen)
  );

  assign active  = mode_meas_i & chan_en_i & clk_gate_i;
  assign running = active && (st_q == ST_RUN);

  // compare stop beats a same-cycle edge; an edge beats underflow
  always_comb begin
    outc = OUT_NONE;
    if (running) begin
      if (stop_seen)                    outc = OUT_HIT;
      else if (edge_seen)               outc = OUT_CAP;
      else if (tick_i && cnt_q == '0)   outc = OUT_UFL;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_RUN;
      cnt_q     <= CNT_MAX;
      cap_q     <= '0;
      cap_evt_q <= 1'b0;
      hit_evt_q <= 1'b0;
      ufl_evt_q <= 1'b0;
    end else begin
      cap_evt_q <= (outc == OUT_CAP);
      hit_evt_q <= (outc == OUT_HIT);
      ufl_evt_q <= (outc == OUT_UFL);
      if (!active) begin
        st_q  <= ST_RUN;
        cnt_q <= CNT_MAX;
      end else if (st_q == ST_RUN) begin
        if (outc != OUT_NONE) st_q  <= ST_DONE;
        else if (tick_i)      cnt_q <= cnt_q - ONE;
        if (outc == OUT_CAP)  cap_q <= cnt_q;
      end else if (tick_i) begin
        cnt_q <= CNT_MAX;
        st_q  <= ST_RUN;
      end
    end
  end

  assign count_o   = cnt_q;
  assign capture_o = cap_q;
  assign cap_evt_o = cap_evt_q;
  assign hit_evt_o = hit_evt_q;
  assign ufl_evt_o = ufl_evt_q;
endmodule

// File: rtl/fan_tach_channel_chk.sv
module fan_tach_channel_chk #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             tick_i,
  input logic             mode_meas_i,
  input logic             chan_en_i,
  input logic             clk_gate_i,
  input logic [3:0]       cmp_cfg_i,
  input logic [CNT_W-1:0] count_o,
  input logic [CNT_W-1:0] capture_o,
  input logic             cap_evt_o,
  input logic             hit_evt_o,
  input logic             ufl_evt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] ONE     = {{(CNT_W-1){1'b0}}, 1'b1};

  AST_ONE_OUTCOME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({cap_evt_o, hit_evt_o, ufl_evt_o})); // R10

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mode_meas_i && chan_en_i && clk_gate_i) |=> !(cap_evt_o || hit_evt_o || ufl_evt_o)); // R2

  AST_COUNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_o != $past(count_o)) |-> (count_o == $past(count_o) - ONE || count_o == CNT_MAX)); // R1

  AST_NO_TICK_NO_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(tick_i) && count_o != $past(count_o)) |-> count_o == CNT_MAX); // R11

  AST_CAPTURE_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_evt_o |-> capture_o == count_o); // R4

  AST_UFL_AT_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ufl_evt_o |-> (count_o == '0 && $stable(capture_o))); // R5

  AST_HIT_KEEPS_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_evt_o |-> $stable(capture_o)); // R6

  AST_FORCE_AT_MAX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_evt_o && $past(cmp_cfg_i[3])) |-> count_o == CNT_MAX); // R7
endmodule

bind fan_tach_channel fan_tach_channel_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .tick_i     (tick_i),
  .mode_meas_i(mode_meas_i),
  .chan_en_i  (chan_en_i),
  .clk_gate_i (clk_gate_i),
  .cmp_cfg_i  (cmp_cfg_i),
  .count_o    (count_o),
  .capture_o  (capture_o),
  .cap_evt_o  (cap_evt_o),
  .hit_evt_o  (hit_evt_o),
  .ufl_evt_o  (ufl_evt_o)
);

// File: tb/tb_fan_tach_channel.sv
`timescale 1ns/1ps
module tb_fan_tach_channel;
  localparam logic [1:0] K_NONE = 2'd0;
  localparam logic [1:0] K_CAP  = 2'd1;
  localparam logic [1:0] K_HIT  = 2'd2;
  localparam logic [1:0] K_UFL  = 2'd3;

  typedef struct packed {
    logic        sel;
    logic        rise;
    logic [3:0]  cfg;
    logic [15:0] cmp;
    logic [16:0] ticks;
    logic        decoy;
    logic [1:0]  kind;
    logic [15:0] val;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b1, 4'h0, 16'h0000, 17'd100, 1'b0, K_CAP, 16'hFF9B}, // R1 R4
    '{1'b1, 1'b1, 4'h0, 16'h0000, 17'd37,  1'b1, K_CAP, 16'hFFDA}, // R3 pin B
    '{1'b0, 1'b0, 4'h0, 16'h0000, 17'd5,   1'b1, K_CAP, 16'hFFFA}, // R3 R8 falling
    '{1'b0, 1'b1, 4'h8, 16'h0000, 17'd3,   1'b0, K_HIT, 16'hFFFF}, // R6 force
    '{1'b0, 1'b1, 4'h4, 16'hFFF0, 17'd40,  1'b0, K_HIT, 16'hFFF0}, // R6 equal
    '{1'b0, 1'b1, 4'h2, 16'hFFF0, 17'd40,  1'b0, K_HIT, 16'hFFEF}, // R6 below
    '{1'b0, 1'b1, 4'h2, 16'h0000, 17'd50,  1'b0, K_CAP, 16'hFFCD}, // R6 below, zero target
    '{1'b0, 1'b1, 4'hC, 16'hFFF0, 17'd40,  1'b0, K_HIT, 16'hFFFF}, // R7
    '{1'b0, 1'b1, 4'h6, 16'hFFF0, 17'd40,  1'b0, K_HIT, 16'hFFF0}, // R7
    '{1'b0, 1'b1, 4'h5, 16'hFFE0, 17'd10,  1'b0, K_CAP, 16'hFFF5}, // R9
    '{1'b0, 1'b1, 4'h4, 16'hFFF5, 17'd10,  1'b0, K_HIT, 16'hFFF5}  // R6 boundary
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        tach_a = 1'b0, tach_b = 1'b0, tach_sel = 1'b0;
  logic        mode_meas = 1'b0, chan_en = 1'b0, clk_gate = 1'b0, edge_rise = 1'b1;
  logic [3:0]  cmp_cfg = 4'h0;
  logic [15:0] cmp_val = 16'h0;
  logic [15:0] count, capture;
  logic        cap_evt, hit_evt, ufl_evt;

  int checks = 0;
  int errors = 0;
  logic        armed = 1'b0;
  int          n_ev = 0;
  logic [1:0]  ev_kind = K_NONE;
  logic [15:0] ev_val = 16'h0;
  logic [15:0] last_cap = 16'h0;

  always #2 clk = ~clk;

  fan_tach_channel dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick),
    .tach_a_i(tach_a), .tach_b_i(tach_b), .tach_sel_i(tach_sel),
    .mode_meas_i(mode_meas), .chan_en_i(chan_en), .clk_gate_i(clk_gate),
    .edge_rise_i(edge_rise), .cmp_cfg_i(cmp_cfg), .cmp_val_i(cmp_val),
    .count_o(count), .capture_o(capture),
    .cap_evt_o(cap_evt), .hit_evt_o(hit_evt), .ufl_evt_o(ufl_evt)
  );

  // records the first outcome after arming
  always @(negedge clk) begin
    if (armed && (cap_evt || hit_evt || ufl_evt)) begin
      if (n_ev == 0) begin
        ev_kind = cap_evt ? K_CAP : (hit_evt ? K_HIT : K_UFL);
        ev_val  = cap_evt ? capture : count;
      end
      n_ev = n_ev + 1;
    end
  end

  task automatic chk(input logic ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", what, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic tick_n(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tick = 1'b1;
    end
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic setup(input logic sel, input logic rise, input logic [3:0] cfg,
                       input logic [15:0] cv, input logic idle);
    @(negedge clk);
    chan_en = 1'b0; mode_meas = 1'b1; clk_gate = 1'b1;
    tach_sel = sel; edge_rise = rise; cmp_cfg = cfg; cmp_val = cv;
    tach_a = idle; tach_b = idle;
    cyc(6);
    n_ev = 0; ev_kind = K_NONE; armed = 1'b1;
    chan_en = 1'b1;
  endtask

  task automatic run_vec(input int idx);
    vec_t v;
    v = VECS[idx];
    setup(v.sel, v.rise, v.cfg, v.cmp, ~v.rise);
    tick_n(int'(v.ticks));
    if (v.decoy) begin
      if (v.sel) tach_a = v.rise; else tach_b = v.rise;
      cyc(8);
      chk(n_ev == 0, $sformatf("R3 vector %0d unselected pin edge", idx), n_ev, 0);
    end
    if (v.sel) tach_b = v.rise; else tach_a = v.rise;
    cyc(8);
    chk(ev_kind == v.kind && ev_val == v.val,
        $sformatf("R4 R6 R7 R8 R9 vector %0d kind/value", idx),
        {14'd0, ev_kind, ev_val}, {14'd0, v.kind, v.val});
    if (v.kind == K_CAP) last_cap = v.val;
    armed = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual 1 expected 0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    cyc(3);
    // R1 reset state
    chk(count == 16'hFFFF, "R1 reset count", count, 16'hFFFF);
    chk(capture == 16'h0 && !cap_evt && !hit_evt && !ufl_evt, "R1 reset capture/strobes",
        {capture, 13'd0, cap_evt, hit_evt, ufl_evt}, 0);
    rst_n = 1'b1;
    cyc(2);

    for (int i = 0; i < NV; i++) run_vec(i);

    // R2: each gating bit alone blocks the channel
    for (int g = 0; g < 3; g++) begin
      setup(1'b0, 1'b1, 4'h0, 16'h0, 1'b0);
      mode_meas = (g != 0); chan_en = (g != 1); clk_gate = (g != 2);
      tick_n(20);
      tach_a = 1'b1;
      cyc(8);
      chk(n_ev == 0 && count == 16'hFFFF, $sformatf("R2 gate %0d inactive", g),
          {n_ev[15:0], count}, {16'd0, 16'hFFFF});
      armed = 1'b0;
    end

    // R11 hold then reload, R1 stepping after reload
    setup(1'b0, 1'b1, 4'h0, 16'h0, 1'b0);
    tick_n(7);
    tach_a = 1'b1;
    cyc(8);
    chk(ev_kind == K_CAP && ev_val == 16'hFFF8, "R4 capture before reload", ev_val, 16'hFFF8);
    chk(count == 16'hFFF8, "R11 count held after outcome", count, 16'hFFF8);
    tick_n(1);
    chk(count == 16'hFFFF, "R11 reload on tick", count, 16'hFFFF);
    tick_n(3);
    chk(count == 16'hFFFC, "R1 step after reload", count, 16'hFFFC);
    armed = 1'b0;
    last_cap = 16'hFFF8;

    // R8 wrong direction ignored
    setup(1'b0, 1'b1, 4'h0, 16'h0, 1'b1);
    tick_n(4);
    tach_a = 1'b0;
    cyc(8);
    chk(n_ev == 0, "R8 falling edge ignored in rising mode", n_ev, 0);
    tach_a = 1'b1;
    cyc(8);
    chk(ev_kind == K_CAP && ev_val == 16'hFFFB, "R8 rising edge counted", ev_val, 16'hFFFB);
    armed = 1'b0;
    last_cap = 16'hFFFB;

    // R5 underflow, below-rule disabled by zero target (R6)
    setup(1'b0, 1'b1, 4'h2, 16'h0, 1'b0);
    tick_n(65536);
    cyc(4);
    chk(ev_kind == K_UFL && ev_val == 16'h0, "R5 underflow kind/count",
        {14'd0, ev_kind, ev_val}, {14'd0, K_UFL, 16'h0});
    chk(capture == last_cap, "R5 capture unchanged on underflow", capture, last_cap);
    chk(n_ev == 1, "R10 single strobe for underflow", n_ev, 1);
    armed = 1'b0;

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule